// File: doc/BRIEF.md
# Segmented Memory Controller

This block sits between a single bus master and up to four memory regions. The byte address presented by the master is split into a segment number and an in-segment offset. Each segment is steered either to a zero-wait on-chip RAM or to an external asynchronous memory port shared by an external SRAM and an external NOR-style flash. Every segment has its own software-written descriptor. The descriptor chooses the device kind, the external data width (8, 16 or 32 bits) and a wait-state count.

A 32-bit master access to a narrow external segment is broken into several external beats, taken in ascending byte order. Each beat holds the address, the chip select and the read or write strobe for one cycle more than the segment's wait count. One idle strobe cycle separates consecutive beats. On-chip accesses finish in the cycle they are presented.

The master port uses valid/ready. The master raises `cpu_valid` and then holds the address, direction and write data unchanged until it sees `cpu_ready` high at a clock edge. It must not raise a second request in that same edge's following cycle until it has changed the request fields. `cpu_ready` is never high without `cpu_valid`. Back-pressure is the number of cycles `cpu_ready` stays low. The descriptor port is a plain write strobe with combinational readback. A descriptor written during an external access takes effect at the next access.

Top module: `segmem_ctrl`

## Requirements
- R1: The segment is `cpu_addr[23:22]`, and `ext_addr` carries the offset bits `[21:0]`. During an external access, only `ext_cs_n[seg]` is low. At all other times every chip select is high.
- R2: A segment whose descriptor device field is 0 (on-chip RAM) answers with `cpu_ready` in the same cycle as `cpu_valid`. Word index is `cpu_addr[AW+1:2]`. The chip selects and strobes stay inactive.
- R3: The descriptor width field selects the beat count: 0 = 8-bit (4 beats), 1 = 16-bit (2 beats), 2 = 32-bit (1 beat). Beat k uses address `offset&~3 + k*bytes` and the low data lanes, least significant byte first.
- R4: With wait field W, each beat keeps its strobe low for W+1 cycles. `cpu_ready` rises N*(W+2)-1 cycles after the cycle in which the request is first presented.
- R5: Between consecutive beats there is exactly one cycle in which both strobes are high and the chip select stays low.
- R6: Read data returned with `cpu_ready` is the little-endian assembly of the bytes read over all beats.
- R7: Writes drive `ext_we_n` low with `ext_dout` carrying the beat's bytes in its low lanes. Reads drive `ext_oe_n` low. The two strobes are never low together.
- R8: After reset, descriptor 0 reads 0x9F (flash, 16-bit, 15 waits). Descriptors 1 to 3 read 0x20 (on-chip RAM, 32-bit, 0 waits). Layout: [7:6] device (0 on-chip, 1 external SRAM, 2 external flash), [5:4] width, [3:0] wait.
- R9: Writing `cfg_wdata` with `cfg_wr` high updates descriptor `cfg_idx` at the clock edge. `cfg_rdata` shows descriptor `cfg_idx`, and new settings govern subsequent accesses.
- R10: `cpu_ready` is high only while `cpu_valid` is high. It is high for exactly one cycle per external transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared with the master |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_valid | input | 1 | Request present |
| cpu_ready | output | 1 | Request completes this cycle |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 24 | Byte address, segment in top two bits |
| cpu_wdata | input | 32 | Write data |
| cpu_rdata | output | 32 | Read data, valid with cpu_ready |
| cfg_wr | input | 1 | Descriptor write strobe |
| cfg_idx | input | 2 | Descriptor selected for write and readback |
| cfg_wdata | input | 8 | Descriptor write value |
| cfg_rdata | output | 8 | Selected descriptor value |
| ext_addr | output | 22 | External byte address within segment |
| ext_cs_n | output | 4 | Per-segment chip selects, active low |
| ext_oe_n | output | 1 | External output enable, active low |
| ext_we_n | output | 1 | External write enable, active low |
| ext_dout | output | 32 | External write data |
| ext_din | input | 32 | External read data |

## Verification
The bench builds the block with the default four segments and 24-bit addresses, but with the on-chip RAM shrunk to 64 words. This lets a random address walk revisit on-chip locations often. Its external memory model is 256 bytes per segment, so read-after-write pairs and data left over from earlier widths collide. Random descriptors cover every width with wait counts up to 15. This puts the longest access (four beats, 15 waits) and the zero-wait on-chip path side by side in the same run.

// File: rtl/smc_pkg.sv
package smc_pkg;

  typedef enum logic [1:0] {
    DEV_ONCHIP = 2'd0,
    DEV_XSRAM  = 2'd1,
    DEV_XFLASH = 2'd2,
    DEV_RSVD   = 2'd3
  } dev_e;

  typedef enum logic [1:0] {
    BW_8   = 2'd0,
    BW_16  = 2'd1,
    BW_32  = 2'd2,
    BW_RSV = 2'd3
  } bw_e;

  // descriptor byte: [7:6] device, [5:4] width, [3:0] wait states
  typedef struct packed {
    dev_e       dev;
    bw_e        bw;
    logic [3:0] ws;
  } seg_cfg_t;

  localparam seg_cfg_t BOOT_CFG = '{dev: DEV_XFLASH, bw: BW_16, ws: 4'd15};
  localparam seg_cfg_t IDLE_CFG = '{dev: DEV_ONCHIP, bw: BW_32, ws: 4'd0};

  function automatic logic [2:0] beats_of(input bw_e bw);
    case (bw)
      BW_8:    beats_of = 3'd4;
      BW_16:   beats_of = 3'd2;
      default: beats_of = 3'd1;
    endcase
  endfunction

  function automatic logic [1:0] lg_bytes(input bw_e bw);
    case (bw)
      BW_8:    lg_bytes = 2'd0;
      BW_16:   lg_bytes = 2'd1;
      default: lg_bytes = 2'd2;
    endcase
  endfunction

endpackage

// File: rtl/smc_cfg_regs.sv
module smc_cfg_regs
  import smc_pkg::*;
#(
  parameter int SEGS  = 4,
  localparam int SEG_W = $clog2(SEGS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [SEG_W-1:0] idx,
  input  logic [7:0]       wdata,
  output logic [7:0]       rdata,
  input  logic [SEG_W-1:0] look_seg,
  output seg_cfg_t         look_cfg
);

  seg_cfg_t regs [SEGS];

  for (genvar g = 0; g < SEGS; g++) begin : g_seg
    localparam seg_cfg_t RST_VAL = (g == 0) ? BOOT_CFG : IDLE_CFG;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        regs[g] <= RST_VAL;
      else if (wr && idx == SEG_W'(g))
        regs[g] <= seg_cfg_t'(wdata);
    end
  end

  assign rdata    = regs[idx];
  assign look_cfg = regs[look_seg];

  // R9: a write is visible on readback in the following cycle
  assert_cfg_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && idx == look_seg) |=> (look_cfg == seg_cfg_t'($past(wdata))) || $past(idx) != look_seg);

endmodule

// File: rtl/smc_onchip_ram.sv
module smc_onchip_ram #(
  parameter int WORDS = 256,
  parameter int DW    = 32,
  localparam int AW   = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  assign rdata = mem[addr];

endmodule

// File: rtl/smc_ext_seq.sv
module smc_ext_seq
  import smc_pkg::*;
#(
  parameter int SEGS  = 4,
  parameter int OFF_W = 22,
  localparam int SEG_W = $clog2(SEGS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             req_we,
  input  logic [SEG_W-1:0] req_seg,
  input  logic [OFF_W-1:0] req_off,
  input  logic [31:0]      req_wdata,
  input  seg_cfg_t         req_cfg,
  output logic             busy,
  output logic             done,
  output logic [31:0]      rdata,
  output logic [OFF_W-1:0] ext_addr,
  output logic [SEGS-1:0]  ext_cs_n,
  output logic             ext_oe_n,
  output logic             ext_we_n,
  output logic [31:0]      ext_dout,
  input  logic [31:0]      ext_din
);

  typedef enum logic [1:0] {ST_IDLE, ST_STROBE, ST_GAP} st_e;

  st_e              st;
  logic             we_q;
  logic [SEG_W-1:0] seg_q;
  logic [OFF_W-1:0] base_q;
  logic [31:0]      wdata_q;
  bw_e              bw_q;
  logic [3:0]       ws_q;
  logic [3:0]       cnt_q;
  logic [1:0]       beat_q;
  logic [31:0]      rbuf_q;

  logic [1:0]  byte_idx;
  logic [4:0]  bit_idx;
  logic        last_beat;
  logic        beat_end;
  logic [31:0] merged;

  assign byte_idx  = 2'(beat_q << lg_bytes(bw_q));
  assign bit_idx   = {byte_idx, 3'b000};
  assign last_beat = ({1'b0, beat_q} == beats_of(bw_q) - 3'd1);
  assign beat_end  = (st == ST_STROBE) && (cnt_q == 4'd0);

  always_comb begin
    merged = rbuf_q;
    case (bw_q)
      BW_8:    merged[bit_idx +: 8]  = ext_din[7:0];
      BW_16:   merged[bit_idx +: 16] = ext_din[15:0];
      default: merged = ext_din;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      we_q    <= 1'b0;
      seg_q   <= '0;
      base_q  <= '0;
      wdata_q <= '0;
      bw_q    <= BW_32;
      ws_q    <= '0;
      cnt_q   <= '0;
      beat_q  <= '0;
      rbuf_q  <= '0;
    end else begin
      case (st)
        ST_IDLE: if (start) begin
          st      <= ST_STROBE;
          we_q    <= req_we;
          seg_q   <= req_seg;
          base_q  <= {req_off[OFF_W-1:2], 2'b00};
          wdata_q <= req_wdata;
          bw_q    <= req_cfg.bw;
          ws_q    <= req_cfg.ws;
          cnt_q   <= req_cfg.ws;
          beat_q  <= '0;
          rbuf_q  <= '0;
        end
        ST_STROBE: begin
          if (cnt_q != 4'd0) begin
            cnt_q <= cnt_q - 4'd1;
          end else begin
            if (!we_q) rbuf_q <= merged;
            st <= last_beat ? ST_IDLE : ST_GAP;
          end
        end
        ST_GAP: begin
          beat_q <= beat_q + 2'd1;
          cnt_q  <= ws_q;
          st     <= ST_STROBE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign busy     = (st != ST_IDLE);
  assign done     = beat_end && last_beat;
  assign rdata    = merged;
  assign ext_addr = base_q + OFF_W'(byte_idx);
  assign ext_dout = wdata_q >> bit_idx;
  assign ext_oe_n = !((st == ST_STROBE) && !we_q);
  assign ext_we_n = !((st == ST_STROBE) && we_q);

  for (genvar g = 0; g < SEGS; g++) begin : g_cs
    assign ext_cs_n[g] = !(busy && seg_q == SEG_W'(g));
  end

  // R4: strobe, address and data hold while wait states remain
  assert_strobe_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_STROBE && cnt_q != 4'd0) |=> (st == ST_STROBE) && $stable(ext_addr) && $stable(ext_dout));

  // R5: the inter-beat cycle releases the strobes but keeps the chip selected
  assert_gap_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_GAP) |-> ext_oe_n && ext_we_n && !(&ext_cs_n));

  // R7: read and write strobes are mutually exclusive
  assert_strobe_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(!ext_oe_n && !ext_we_n));

endmodule

// File: rtl/segmem_ctrl.sv
module segmem_ctrl
  import smc_pkg::*;
#(
  parameter int SEGS      = 4,
  parameter int ADDR_W    = 24,
  parameter int INT_WORDS = 256,
  localparam int SEG_W    = $clog2(SEGS),
  localparam int OFF_W    = ADDR_W - SEG_W,
  localparam int IAW      = $clog2(INT_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_valid,
  output logic              cpu_ready,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [31:0]       cpu_wdata,
  output logic [31:0]       cpu_rdata,
  input  logic              cfg_wr,
  input  logic [SEG_W-1:0]  cfg_idx,
  input  logic [7:0]        cfg_wdata,
  output logic [7:0]        cfg_rdata,
  output logic [OFF_W-1:0]  ext_addr,
  output logic [SEGS-1:0]   ext_cs_n,
  output logic              ext_oe_n,
  output logic              ext_we_n,
  output logic [31:0]       ext_dout,
  input  logic [31:0]       ext_din
);

  logic [SEG_W-1:0] seg;
  logic [OFF_W-1:0] off;
  seg_cfg_t         cur_cfg;
  logic             is_onchip;
  logic             busy;
  logic             done;
  logic [31:0]      ext_rdata;
  logic [31:0]      ram_rdata;
  logic             ram_we;
  logic             start;

  assign seg = cpu_addr[ADDR_W-1 -: SEG_W];
  assign off = cpu_addr[OFF_W-1:0];

  smc_cfg_regs #(.SEGS(SEGS)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (cfg_wr),
    .idx      (cfg_idx),
    .wdata    (cfg_wdata),
    .rdata    (cfg_rdata),
    .look_seg (seg),
    .look_cfg (cur_cfg)
  );

  assign is_onchip = (cur_cfg.dev == DEV_ONCHIP);
  assign start     = cpu_valid && !busy && !is_onchip;
  assign ram_we    = cpu_valid && !busy && is_onchip && cpu_we;

  smc_onchip_ram #(.WORDS(INT_WORDS), .DW(32)) u_ram (
    .clk   (clk),
    .we    (ram_we),
    .addr  (off[IAW+1:2]),
    .wdata (cpu_wdata),
    .rdata (ram_rdata)
  );

  smc_ext_seq #(.SEGS(SEGS), .OFF_W(OFF_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .req_we    (cpu_we),
    .req_seg   (seg),
    .req_off   (off),
    .req_wdata (cpu_wdata),
    .req_cfg   (cur_cfg),
    .busy      (busy),
    .done      (done),
    .rdata     (ext_rdata),
    .ext_addr  (ext_addr),
    .ext_cs_n  (ext_cs_n),
    .ext_oe_n  (ext_oe_n),
    .ext_we_n  (ext_we_n),
    .ext_dout  (ext_dout),
    .ext_din   (ext_din)
  );

  assign cpu_ready = cpu_valid && (busy ? done : is_onchip);
  assign cpu_rdata = busy ? ext_rdata : ram_rdata;

  // R1: at most one segment selected at any time
  assert_cs_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~ext_cs_n));

  // R2: on-chip request answered at once with no external activity
  assert_onchip_zero_wait_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_valid && !busy && is_onchip) |-> cpu_ready && (&ext_cs_n) && ext_oe_n && ext_we_n);

  // R10: ready never without valid
  assert_ready_needs_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |-> cpu_valid);

  // R10: an external completion is a single-cycle pulse
  assert_ready_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ready && busy) |=> !busy);

endmodule

// File: tb/sim_segmem_ctrl.sv
module sim_segmem_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int IWORDS     = 64;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        cpu_valid = 0, cpu_we = 0;
  logic [23:0] cpu_addr = '0;
  logic [31:0] cpu_wdata = '0;
  logic        cpu_ready;
  logic [31:0] cpu_rdata;
  logic        cfg_wr = 0;
  logic [1:0]  cfg_idx = '0;
  logic [7:0]  cfg_wdata = '0;
  logic [7:0]  cfg_rdata;
  logic [21:0] ext_addr;
  logic [3:0]  ext_cs_n;
  logic        ext_oe_n, ext_we_n;
  logic [31:0] ext_dout;
  logic [31:0] ext_din;

  int errors = 0, checks = 0, cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  segmem_ctrl #(.SEGS(4), .ADDR_W(24), .INT_WORDS(IWORDS)) u0 (
    .clk, .rst_n, .cpu_valid, .cpu_ready, .cpu_we, .cpu_addr, .cpu_wdata,
    .cpu_rdata, .cfg_wr, .cfg_idx, .cfg_wdata, .cfg_rdata, .ext_addr,
    .ext_cs_n, .ext_oe_n, .ext_we_n, .ext_dout, .ext_din);

  // external memory model: 256 bytes per segment
  logic [7:0] xm [1024];
  logic [7:0] shadow_cfg [4];
  logic [31:0] imem [IWORDS];

  function automatic int cs_seg(input logic [3:0] csn);
    for (int i = 0; i < 4; i++) if (!csn[i]) return i;
    return -1;
  endfunction

  function automatic int nbytes(input logic [7:0] c);
    case (c[5:4]) 2'd0: return 1; 2'd1: return 2; default: return 4; endcase
  endfunction

  function automatic int nbeats(input logic [7:0] c);
    return 4 / nbytes(c);
  endfunction

  function automatic int exp_lat(input logic [7:0] c);
    if (c[7:6] == 2'd0) return 0;
    return nbeats(c) * (int'(c[3:0]) + 2) - 1;
  endfunction

  function automatic logic [31:0] xword(input int s, input logic [7:0] a);
    logic [31:0] w;
    for (int k = 0; k < 4; k++) w[8*k +: 8] = xm[s*256 + int'(8'(a + 8'(k)))];
    return w;
  endfunction

  always_comb begin
    int s;
    s = cs_seg(ext_cs_n);
    ext_din = (s >= 0) ? xword(s, ext_addr[7:0]) : 32'hDEAD_BEEF;
  end

  int mon_strobe, mon_beats, mon_badcs;
  logic prev_strobe = 0;
  always @(negedge clk) begin
    logic st;
    int s;
    cycles++;
    st = !ext_oe_n || !ext_we_n;
    if (st) mon_strobe++;
    if (st && !prev_strobe) mon_beats++;
    prev_strobe = st;
    if ($countones(~ext_cs_n) > 1) mon_badcs++;
    s = cs_seg(ext_cs_n);
    if (!ext_we_n && s >= 0)
      for (int k = 0; k < nbytes(shadow_cfg[s]); k++)
        xm[s*256 + int'(8'(ext_addr[7:0] + 8'(k)))] = ext_dout[8*k +: 8];
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input int idx, input logic [7:0] v);
    @(negedge clk);
    cfg_wr = 1; cfg_idx = 2'(idx); cfg_wdata = v;
    @(negedge clk);
    cfg_wr = 0;
    shadow_cfg[idx] = v;
  endtask

  task automatic xfer(input bit we, input logic [23:0] a, input logic [31:0] wd,
                      output logic [31:0] rd, output int lat);
    @(negedge clk);
    mon_strobe = 0; mon_beats = 0; prev_strobe = 0;
    cpu_valid = 1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
    lat = 0;
    #1;
    while (!cpu_ready) begin
      @(negedge clk);
      lat++;
      #1;
    end
    rd = cpu_rdata;
    @(negedge clk);
    cpu_valid = 0;
    if (a[23:22] != 2'd0 || shadow_cfg[0][7:6] == 2'd0)
      ; // no-op
    if (shadow_cfg[a[23:22]][7:6] == 2'd0 && we) imem[a[7:2]] = wd;
  endtask

  // full access with latency, beat and data checks
  task automatic run(input bit we, input logic [23:0] a, input logic [31:0] wd);
    logic [31:0] rd, expd;
    int lat;
    int s;
    logic [7:0] c;
    logic [7:0] ab;
    s = int'(a[23:22]);
    c = shadow_cfg[s];
    ab = {a[7:2], 2'b00};
    expd = (c[7:6] == 2'd0) ? imem[a[7:2]] : xword(s, ab);
    xfer(we, a, wd, rd, lat);
    if (c[7:6] == 2'd0) begin
      chk(lat == 0, "R2 zero-wait latency", lat, 0);
      chk(mon_strobe == 0, "R2 no external strobe", mon_strobe, 0);
    end else begin
      chk(lat == exp_lat(c), "R4 latency", lat, exp_lat(c));
      chk(mon_strobe == nbeats(c) * (int'(c[3:0]) + 1), "R4 strobe cycles", mon_strobe,
          nbeats(c) * (int'(c[3:0]) + 1));
      chk(mon_beats == nbeats(c), "R3/R5 separate beats", mon_beats, nbeats(c));
    end
    if (!we) chk(rd == expd, "R6 read data", rd, expd);
    else if (c[7:6] != 2'd0) chk(xword(s, ab) == wd, "R7 written bytes LSB first", xword(s, ab), wd);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      if (cycles > 150000) begin
        errors++; checks++;
        $display("FAIL watchdog actual=%0d expected<150000", cycles);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] rd;
    int lat;
    void'($urandom(32'h5E6_1A7));
    for (int i = 0; i < 1024; i++) xm[i] = 8'(i * 7 + 3);
    for (int i = 0; i < IWORDS; i++) imem[i] = 32'h0;
    shadow_cfg[0] = 8'h9F; shadow_cfg[1] = 8'h20; shadow_cfg[2] = 8'h20; shadow_cfg[3] = 8'h20;

    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R8: reset values and idle external port
    for (int i = 0; i < 4; i++) begin
      cfg_idx = 2'(i); #1;
      chk(cfg_rdata == shadow_cfg[i], "R8 reset descriptor", cfg_rdata, shadow_cfg[i]);
    end
    chk(ext_cs_n == 4'hF && ext_oe_n && ext_we_n, "R1 idle strobes", {ext_cs_n, ext_oe_n, ext_we_n}, 6'h3F);
    chk(!cpu_ready, "R10 idle ready", cpu_ready, 0);

    // on-chip RAM must be initialized before reads: fill all words
    for (int w = 0; w < IWORDS; w++) run(1, {2'd1, 14'd0, 6'(w), 2'b00}, 32'h1000 + w);

    // boot segment: 16-bit flash, 15 waits
    run(0, 24'h000010, 32'h0);
    // R1: address offset reaches ext_addr with segment select
    run(0, 24'h3FFFF0 & 24'h3FFFFC, 32'h0);

    // R9: reconfigure segment 2 to external SRAM 8-bit, 0 waits
    cfg_write(2, 8'h40);
    cfg_idx = 2'd2; #1;
    chk(cfg_rdata == 8'h40, "R9 readback", cfg_rdata, 8'h40);
    run(1, 24'h800020, 32'h11223344);
    chk(xm[2*256 + 8'h20] == 8'h44 && xm[2*256 + 8'h23] == 8'h11, "R3 LSB first",
        {xm[2*256+8'h23], xm[2*256+8'h20]}, 16'h1144);
    run(0, 24'h800020, 32'h0);

    // 32-bit external, 3 waits
    cfg_write(3, 8'h63);
    run(1, 24'hC00044, 32'hCAFEF00D);
    run(0, 24'hC00044, 32'h0);

    // on-chip path and mid-access descriptor stability
    run(1, 24'h400008, 32'hA5A5_5A5A);
    run(0, 24'h400008, 32'h0);

    // random mix
    for (int it = 0; it < 120; it++) begin
      int s;
      logic [7:0] c;
      logic [23:0] a;
      logic [31:0] d;
      s = int'($urandom_range(0, 3));
      if ($urandom_range(0, 3) == 0) begin
        c = {2'($urandom_range(0, 2)), 2'($urandom_range(0, 2)), 4'($urandom_range(0, 15))};
        cfg_write(s, c);
      end
      a = {2'(s), 14'($urandom), 6'($urandom), 2'b00};
      d = $urandom;
      run(1, a, d);
      run(0, a, 32'h0);
      if (!cpu_ready) ; // ready already released by task
    end

    chk(mon_badcs == 0, "R1 single chip select", mon_badcs, 0);
    @(negedge clk);
    chk(!cpu_ready, "R10 ready released", cpu_ready, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule